// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a byte-oriented asynchronous serial port that a processor drives through seven 32-bit word registers. Bytes written to the transmit data word are queued in an 8-entry buffer and sent as frames of one low start bit, eight data bits (least significant first) and one or two high stop bits. Each bit lasts a programmable number of clock cycles. Incoming frames on the receive pin are synchronised, sampled in the middle of each bit and queued in a second 8-entry buffer, which software drains by reading the receive data word.

Status lives in bit 31 of the two data words: a full flag on the transmit side and an empty flag on the receive side. The interrupt sources are not events. Each is a level comparison between a buffer's fill count and a 3-bit threshold: the transmit source holds while the transmit fill is below its threshold, and the receive source holds while the receive fill is above its threshold. Two enable bits gate these levels onto a single interrupt line. Parity, break, flow control, modem lines and word sizes other than 8 bits are not provided.

Top module: `wm_uart`

## Requirements
- R1: After reset the line output is high, the interrupt output is low, both buffers are empty, and every register reads zero except the receive data word, whose bit 31 (empty) is 1.
- R2: With transmit enabled, each queued byte goes out as a low start bit, eight data bits LSB first and a high stop bit. Every bit lasts DIV+1 clock cycles, where DIV is bits 15:0 of the word at byte offset 0x18.
- R3: With bit 1 of the transmit control word (offset 0x08) clear, back-to-back frames start 10 bit periods apart. With it set, two stop bits are sent and frames start 11 bit periods apart.
- R4: A write to offset 0x00 queues bits 7:0. Reading offset 0x00 gives bit 31 = 1 when 8 bytes are queued. A write while full is dropped, and queued bytes leave in write order.
- R5: Frames start only while bit 0 of the transmit control word is 1. While it is 0 the line stays high and queued bytes are kept.
- R6: Reading offset 0x04 returns the oldest received byte in bits 7:0 with bit 31 = 0 and removes it. When nothing is held, the read returns bit 31 = 1 and removes nothing.
- R7: The receiver samples each bit at mid-bit using DIV. A low pulse that is no longer high by mid start bit is taken as a start; one that is high again by mid start bit produces no byte, and the next real frame is still received.
- R8: Frames arriving while bit 0 of the receive control word (offset 0x0C) is 0 are not stored.
- R9: A byte that completes while 8 bytes are held is dropped, and the 8 held bytes are unchanged.
- R10: Pending bit 0 (offset 0x14) is 1 exactly while the transmit fill count is less than bits 18:16 of the transmit control word.
- R11: Pending bit 1 is 1 exactly while the receive fill count is greater than bits 18:16 of the receive control word.
- R12: The interrupt output is 1 when any pending bit is set together with the same bit of the enable word (offset 0x10; bit 0 transmit, bit 1 receive). Writes to the pending word have no effect.
- R13: The control, enable and divisor fields read back as written. Transmit control holds enable in bit 0, two-stop in bit 1 and the threshold in 18:16. Receive control holds enable in bit 0 and the threshold in 18:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte address of the register word |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (pops the receive buffer at offset 0x04) |
| rd_data | output | 32 | Combinational read data for `addr` |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Level interrupt |

## Verification
The transmitter is tested with asymmetric bytes such as 0xA5, 0x0F and 0x81. These catch bit-order and shift errors, and the distance between back-to-back start edges separates the one-stop frame from the two-stop frame. A run of eight distinct queued bytes plus one extra shows ordering, the full flag and the dropped ninth write. On the receive side, single bytes, a one-cycle glitch, a disabled receiver and a nine-byte burst separate correct mid-bit sampling from false starts, ignored enables and overflow corruption. Watermark tests move the fill count across each threshold and toggle the enables, which separates the strict "less than" and "greater than" comparisons from off-by-one variants.

// File: rtl/wm_uart_pkg.sv
package wm_uart_pkg;
   localparam int ADDR_W    = 5;
   localparam int BYTE_W    = 8;
   localparam int FLAG_BIT  = 31;
   localparam int EN_BIT    = 0;
   localparam int NSTOP_BIT = 1;
   localparam int WM_LSB    = 16;

   localparam logic [2:0] W_TXDATA = 3'd0;
   localparam logic [2:0] W_RXDATA = 3'd1;
   localparam logic [2:0] W_TXCTRL = 3'd2;
   localparam logic [2:0] W_RXCTRL = 3'd3;
   localparam logic [2:0] W_IE     = 3'd4;
   localparam logic [2:0] W_IP     = 3'd5;
   localparam logic [2:0] W_DIV    = 3'd6;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/wm_uart_fifo.sv
module wm_uart_fifo #(
   parameter  int WIDTH = 8,
   parameter  int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("wm_uart_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/wm_uart_tx.sv
module wm_uart_tx #(
   parameter  int WIDTH   = 8,
   parameter  int DIV_W   = 16,
   localparam int FRAME_W = WIDTH + 3,
   localparam int BIT_CW  = $clog2(FRAME_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             two_stop,
   input  logic [DIV_W-1:0] div,
   input  logic             avail,
   input  logic [WIDTH-1:0] data,
   output logic             take,
   output logic             busy,
   output logic             txd
);
   logic [FRAME_W-1:0] shreg;
   logic [BIT_CW-1:0]  bits_left;
   logic [DIV_W-1:0]   cnt;
   logic               tick, last;

   assign tick = busy && (cnt == '0);
   assign last = tick && (bits_left == BIT_CW'(1));
   assign take = enable && avail && (!busy || last);
   assign txd  = shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '1;
         bits_left <= '0;
         cnt       <= '0;
         busy      <= 1'b0;
      end else if (take) begin
         shreg     <= {2'b11, data, 1'b0};
         bits_left <= two_stop ? BIT_CW'(FRAME_W) : BIT_CW'(FRAME_W - 1);
         cnt       <= div;
         busy      <= 1'b1;
      end else if (tick) begin
         shreg     <= {1'b1, shreg[FRAME_W-1:1]};
         bits_left <= bits_left - 1'b1;
         cnt       <= div;
         if (last) busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/wm_uart_rx.sv
module wm_uart_rx
   import wm_uart_pkg::*;
#(
   parameter  int WIDTH = 8,
   parameter  int DIV_W = 16,
   localparam int BIT_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] div,
   input  logic             rxd,
   output logic             valid,
   output logic [WIDTH-1:0] data
);
   logic [1:0]       sync;
   logic             rx_s, rx_prev;
   rx_state_e        state;
   logic [DIV_W-1:0] cnt;
   logic [BIT_W-1:0] bitn;

   assign rx_s = sync[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync    <= 2'b11;
         rx_prev <= 1'b1;
         state   <= RX_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         data    <= '0;
         valid   <= 1'b0;
      end else begin
         sync    <= {sync[0], rxd};
         rx_prev <= rx_s;
         valid   <= 1'b0;
         if (!enable) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE: if (rx_prev && !rx_s) begin
                  state <= RX_START;
                  cnt   <= div >> 1;
               end
               RX_START: if (cnt == '0) begin
                  state <= rx_s ? RX_IDLE : RX_DATA;
                  cnt   <= div;
                  bitn  <= '0;
               end else cnt <= cnt - 1'b1;
               RX_DATA: if (cnt == '0) begin
                  data <= {rx_s, data[WIDTH-1:1]};
                  cnt  <= div;
                  if (bitn == BIT_W'(WIDTH - 1)) state <= RX_STOP;
                  else bitn <= bitn + 1'b1;
               end else cnt <= cnt - 1'b1;
               RX_STOP: if (cnt == '0) begin
                  valid <= 1'b1;
                  state <= RX_IDLE;
               end else cnt <= cnt - 1'b1;
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/wm_uart.sv
module wm_uart
   import wm_uart_pkg::*;
#(
   parameter  int FIFO_DEPTH = 8,
   parameter  int DIV_W      = 16,
   parameter  int WM_W       = 3,
   localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   output logic [31:0]       rd_data,
   output logic              txd,
   input  logic              rxd,
   output logic              irq
);
   generate
      if (DIV_W < 1 || DIV_W > WM_LSB) begin : g_bad_div
         $error("wm_uart: DIV_W must lie in 1..16");
      end
      if (WM_W < 1 || WM_W > CNT_W || WM_LSB + WM_W > FLAG_BIT) begin : g_bad_wm
         $error("wm_uart: WM_W out of range");
      end
   endgenerate

   logic             hit;
   logic [2:0]       sel;
   logic             tx_en, two_stop, rx_en;
   logic [WM_W-1:0]  tx_wm, rx_wm;
   logic [1:0]       ie, ip;
   logic [DIV_W-1:0] div;

   logic              tx_full, tx_empty, tx_take, tx_busy;
   logic [BYTE_W-1:0] tx_head;
   logic [CNT_W-1:0]  tx_count;
   logic              rx_full, rx_empty, rx_valid;
   logic [BYTE_W-1:0] rx_head, rx_byte;
   logic [CNT_W-1:0]  rx_count;

   assign hit = (addr[1:0] == 2'b00);
   assign sel = addr[ADDR_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en <= 1'b0; two_stop <= 1'b0; tx_wm <= '0;
         rx_en <= 1'b0; rx_wm <= '0;
         ie    <= '0;   div <= '0;
      end else if (wr_en && hit) begin
         case (sel)
            W_TXCTRL: begin
               tx_en    <= wr_data[EN_BIT];
               two_stop <= wr_data[NSTOP_BIT];
               tx_wm    <= wr_data[WM_LSB +: WM_W];
            end
            W_RXCTRL: begin
               rx_en <= wr_data[EN_BIT];
               rx_wm <= wr_data[WM_LSB +: WM_W];
            end
            W_IE:    ie  <= wr_data[1:0];
            W_DIV:   div <= wr_data[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   wm_uart_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(wr_en && hit && sel == W_TXDATA), .din(wr_data[BYTE_W-1:0]),
      .pop(tx_take), .dout(tx_head),
      .count(tx_count), .full(tx_full), .empty(tx_empty)
   );

   wm_uart_tx #(.WIDTH(BYTE_W), .DIV_W(DIV_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .enable(tx_en), .two_stop(two_stop),
      .div(div), .avail(!tx_empty), .data(tx_head),
      .take(tx_take), .busy(tx_busy), .txd(txd)
   );

   wm_uart_rx #(.WIDTH(BYTE_W), .DIV_W(DIV_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .enable(rx_en), .div(div),
      .rxd(rxd), .valid(rx_valid), .data(rx_byte)
   );

   wm_uart_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(rx_valid), .din(rx_byte),
      .pop(rd_en && hit && sel == W_RXDATA), .dout(rx_head),
      .count(rx_count), .full(rx_full), .empty(rx_empty)
   );

   assign ip[0] = int'(tx_count) < int'(tx_wm);
   assign ip[1] = int'(rx_count) > int'(rx_wm);
   assign irq   = |(ip & ie);

   always_comb begin
      rd_data = '0;
      if (hit) begin
         case (sel)
            W_TXDATA: rd_data[FLAG_BIT] = tx_full;
            W_RXDATA: begin
               rd_data[FLAG_BIT]     = rx_empty;
               rd_data[BYTE_W-1:0]   = rx_head;
            end
            W_TXCTRL: begin
               rd_data[EN_BIT]            = tx_en;
               rd_data[NSTOP_BIT]         = two_stop;
               rd_data[WM_LSB +: WM_W]    = tx_wm;
            end
            W_RXCTRL: begin
               rd_data[EN_BIT]            = rx_en;
               rd_data[WM_LSB +: WM_W]    = rx_wm;
            end
            W_IE:    rd_data[1:0]       = ie;
            W_IP:    rd_data[1:0]       = ip;
            W_DIV:   rd_data[DIV_W-1:0] = div;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wm_uart_chk.sv
module wm_uart_chk #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4,
   parameter int WM_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] tx_count,
   input logic [CNT_W-1:0] rx_count,
   input logic             tx_busy,
   input logic             tx_en,
   input logic [WM_W-1:0]  tx_wm,
   input logic [1:0]       ie,
   input logic [1:0]       ip,
   input logic             irq
);
   // R4
   tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CNT_W'(DEPTH));

   // R9
   rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(DEPTH));

   // R5
   tx_start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(tx_en));

   // R6
   rx_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rx_count) <= int'($past(rx_count)) + 1) &&
      (int'($past(rx_count)) <= int'(rx_count) + 1));

   // R10
   tx_empty_wm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == '0 && tx_wm != '0) |-> ip[0]);

   // R12
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie == 2'b00) |-> !irq);
endmodule

bind wm_uart wm_uart_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .WM_W(WM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
   .tx_busy(tx_busy), .tx_en(tx_en), .tx_wm(tx_wm), .ie(ie), .ip(ip), .irq(irq)
);

// File: tb/wm_uart_test.sv
module wm_uart_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08,
                          A_RXC = 5'h0C, A_IE = 5'h10, A_IP = 5'h14, A_DIV = 5'h18;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        txd, irq;
   int          n_chk = 0, n_fail = 0, bitp = 1;
   longint      cyc = 0;
   bit          done = 1'b0;

   wm_uart uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
                .rd_en(rd_en), .rd_data(rd_data), .txd(txd), .rxd(rxd), .irq(irq));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rd_data;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic set_div(input int d);
      wr(A_DIV, d);
      bitp = d + 1;
   endtask

   task automatic get_frame(output logic [7:0] b, output longint t0, output bit ok);
      int guard = 0;
      ok = 1'b1; b = '0;
      do begin @(negedge clk); guard++; end while (txd !== 1'b0 && guard < 3000);
      t0 = cyc;
      if (guard >= 3000) ok = 1'b0;
      repeat (bitp/2) @(negedge clk);
      if (txd !== 1'b0) ok = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (bitp) @(negedge clk);
         b[i] = txd;
      end
      repeat (bitp) @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      rxd = 1'b0; repeat (bitp) @(negedge clk);
      for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (bitp) @(negedge clk); end
      rxd = 1'b1; repeat (bitp + 4) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk(txd === 1'b1, "R1 txd idle", {31'b0, txd}, 1);
      chk(irq === 1'b0, "R1 irq low", {31'b0, irq}, 0);
      rd(A_RXD, v); chk(v[31] === 1'b1, "R1 rx empty flag", v, 32'h8000_0000);
      rd(A_TXD, v); chk(v === 0, "R1 TXDATA", v, 0);
      rd(A_TXC, v); chk(v === 0, "R1 TXCTRL", v, 0);
      rd(A_RXC, v); chk(v === 0, "R1 RXCTRL", v, 0);
      rd(A_IE, v);  chk(v === 0, "R1 IE", v, 0);
      rd(A_IP, v);  chk(v === 0, "R1 IP", v, 0);
      rd(A_DIV, v); chk(v === 0, "R1 DIV", v, 0);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr(A_TXC, 32'h0005_0002); rd(A_TXC, v); chk(v === 32'h0005_0002, "R13 TXCTRL readback", v, 32'h0005_0002);
      wr(A_RXC, 32'h0006_0000); rd(A_RXC, v); chk(v === 32'h0006_0000, "R13 RXCTRL readback", v, 32'h0006_0000);
      wr(A_DIV, 32'h0000_1234); rd(A_DIV, v); chk(v === 32'h1234, "R13 DIV readback", v, 32'h1234);
      wr(A_IE, 3); rd(A_IE, v); chk(v === 3, "R13 IE readback", v, 3);
      wr(A_IP, 2); rd(A_IP, v); chk(v === 1, "R12 IP read-only", v, 1);
      wr(A_TXC, 0); wr(A_RXC, 0); wr(A_IE, 0);
   endtask

   task automatic t_tx_basic;
      logic [31:0] v; logic [7:0] b; longint t; bit ok; int lows = 0;
      set_div(3);
      wr(A_TXD, 32'hA5);
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk(lows == 0, "R5 line idle while disabled", lows, 0);
      wr(A_TXC, 1);
      get_frame(b, t, ok);
      chk(ok && b == 8'hA5, "R2 frame 0xA5", {23'b0, ok, b}, {23'b0, 1'b1, 8'hA5});
      rd(A_TXD, v); chk(v[31] === 1'b0, "R4 not full", v, 0);
   endtask

   task automatic t_tx_stop;
      logic [7:0] b1, b2; longint t1, t2; bit ok1, ok2;
      wr(A_TXC, 0); wr(A_TXD, 8'h0F); wr(A_TXD, 8'hF0); wr(A_TXC, 1);
      get_frame(b1, t1, ok1); get_frame(b2, t2, ok2);
      chk(ok1 && ok2 && b1 == 8'h0F && b2 == 8'hF0, "R2 frames 0F,F0", {b1, b2}, 16'h0FF0);
      chk(t2 - t1 == 10 * bitp, "R3 one-stop spacing", 32'(t2 - t1), 10 * bitp);
      wr(A_TXC, 2); wr(A_TXD, 8'h55); wr(A_TXD, 8'h81); wr(A_TXC, 3);
      get_frame(b1, t1, ok1); get_frame(b2, t2, ok2);
      chk(ok1 && ok2 && b1 == 8'h55 && b2 == 8'h81, "R3 frames 55,81", {b1, b2}, 16'h5581);
      chk(t2 - t1 == 11 * bitp, "R3 two-stop spacing", 32'(t2 - t1), 11 * bitp);
      repeat (3 * bitp) @(negedge clk);
      wr(A_TXC, 0);
   endtask

   task automatic t_tx_full;
      logic [31:0] v; logic [7:0] b; longint t; bit ok; int lows = 0;
      for (int i = 0; i < 8; i++) wr(A_TXD, 32'h10 + i);
      rd(A_TXD, v); chk(v[31] === 1'b1, "R4 full flag", v, 32'h8000_0000);
      wr(A_TXD, 32'h99);
      wr(A_TXC, 1);
      for (int i = 0; i < 8; i++) begin
         get_frame(b, t, ok);
         chk(ok && b == 8'(8'h10 + i), "R4 order", {23'b0, ok, b}, {23'b0, 1'b1, 8'(8'h10 + i)});
      end
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk(lows == 0, "R4 write when full dropped", lows, 0);
      wr(A_TXC, 0);
   endtask

   task automatic t_tx_wm;
      logic [31:0] v;
      wr(A_TXC, 32'h0002_0000);
      rd(A_IP, v); chk(v === 1, "R10 0<2 pending", v, 1);
      chk(irq === 1'b0, "R12 masked", {31'b0, irq}, 0);
      wr(A_IE, 1); chk(irq === 1'b1, "R12 tx irq", {31'b0, irq}, 1);
      wr(A_TXD, 8'h01); rd(A_IP, v); chk(v === 1, "R10 1<2 pending", v, 1);
      wr(A_TXD, 8'h02); rd(A_IP, v); chk(v === 0, "R10 2<2 clear", v, 0);
      chk(irq === 1'b0, "R12 irq drops", {31'b0, irq}, 0);
      wr(A_IE, 0); wr(A_TXC, 1);
      repeat (25 * bitp) @(negedge clk);
      wr(A_TXC, 0);
   endtask

   task automatic t_rx;
      logic [31:0] v;
      set_div(7);
      wr(A_RXC, 1);
      rd(A_RXD, v); chk(v[31] === 1'b1, "R6 empty read", v, 32'h8000_0000);
      send(8'h3C);
      rd(A_RXD, v); chk(v === 32'h3C, "R6 read 0x3C", v, 32'h3C);
      rd(A_RXD, v); chk(v[31] === 1'b1, "R6 popped", v, 32'h8000_0000);
      @(negedge clk); rxd = 1'b0; @(negedge clk); rxd = 1'b1;
      repeat (40) @(negedge clk);
      rd(A_RXD, v); chk(v[31] === 1'b1, "R7 glitch rejected", v, 32'h8000_0000);
      send(8'hC3);
      rd(A_RXD, v); chk(v === 32'hC3, "R7 frame after glitch", v, 32'hC3);
      wr(A_RXC, 0); send(8'h77);
      wr(A_RXC, 1);
      rd(A_RXD, v); chk(v[31] === 1'b1, "R8 disabled not stored", v, 32'h8000_0000);
   endtask

   task automatic t_rx_wm;
      logic [31:0] v;
      wr(A_RXC, 32'h0001_0001); wr(A_IE, 2);
      send(8'h11);
      rd(A_IP, v); chk(v === 0, "R11 1>1 clear", v, 0);
      chk(irq === 1'b0, "R12 rx irq low", {31'b0, irq}, 0);
      send(8'h22);
      rd(A_IP, v); chk(v === 2, "R11 2>1 pending", v, 2);
      chk(irq === 1'b1, "R12 rx irq", {31'b0, irq}, 1);
      rd(A_RXD, v); chk(v === 32'h11, "R6 first 0x11", v, 32'h11);
      chk(irq === 1'b0, "R11 irq clears after pop", {31'b0, irq}, 0);
      rd(A_RXD, v); chk(v === 32'h22, "R6 second 0x22", v, 32'h22);
      wr(A_IE, 0); wr(A_RXC, 1);
   endtask

   task automatic t_rx_overflow;
      logic [31:0] v;
      for (int i = 0; i < 9; i++) send(8'(8'h40 + i));
      for (int i = 0; i < 8; i++) begin
         rd(A_RXD, v);
         chk(v === 32'(8'h40 + i), "R9 held bytes", v, 32'(8'h40 + i));
      end
      rd(A_RXD, v); chk(v[31] === 1'b1, "R9 ninth dropped", v, 32'h8000_0000);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_tx_basic;
      t_tx_stop;
      t_tx_full;
      t_tx_wm;
      t_rx;
      t_rx_wm;
      t_rx_overflow;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1-path timeout: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule